// File: doc/BRIEF.md
# Credit-Gated Descriptor Chain Engine

This block is a single-channel mover that works through linked descriptors held in system memory. Software writes a start pointer and then grants credits by writing a count into a credit register. For each credit the engine reads an eight-word descriptor and copies the data block it names from a source buffer to a destination buffer. Each word passes through a transform stage on the way, which is either a straight copy or an XOR with a fixed key. After the copy the engine marks the descriptor done by writing the value 1 into the descriptor's own status word.

Each descriptor decides three things for itself: whether it consumes a credit, whether it raises an interrupt, and whether the engine goes on to the descriptor named by its link word. Descriptors can be linked into a ring. If malformed descriptors are found, or a chain leads to a null link, the engine halts. It then reports an error code and flags, and pulses the interrupt. It stays halted until software clears the status. All memory traffic uses one synchronous port whose read data arrives one cycle after the request.

Top module: `desc_chain_engine`

## Requirements
- R1: After reset the engine is idle, `irq` is low, `chanStat`, `semaCount` and `curPtr` are zero, and no memory access is made.
- R2: A pulse on `semaWr` adds `semaData` to the credit count, which saturates at its maximum value (255 by default) rather than wrapping.
- R3: With a pointer loaded but zero credits, the engine makes no memory access. A pointer write is accepted only while idle, and it arms the engine at that address.
- R4: Descriptor words are laid out at byte offsets 0 link, 4 control, 8 spare, 12 source, 16 destination, 20 byte count, 24 spare, 28 status. A descriptor of N data words costs exactly 8 + 2N + 1 memory accesses.
- R5: The byte count is copied word by word from source to destination. Control bit 5 clear gives an unchanged copy; set gives each word XOR `XOR_KEY`. Words past the count are untouched.
- R6: On completion the engine writes 1 into the status word at offset 28.
- R7: Control bit 1 set lowers the credit count by exactly one when the descriptor completes. When it is clear, the count is unchanged.
- R8: Control bit 0 set gives a single one-cycle `irq` pulse at completion. When it is clear and no error occurs, there is no pulse.
- R9: With control bit 2 set, the engine follows the link word while credits remain. With no credits left it idles, with `curPtr` held on the finished descriptor, and resumes at the linked one when a credit arrives. With bit 2 clear the engine disarms, and later credits start nothing until a new pointer is written.
- R10: A byte count that is not a multiple of 16 is an error: `chanStat` becomes 0x0004_0008 (code 4 in bits 23:16, packet flag 0x08). No data or status is written, no credit is used, and `irq` pulses once.
- R11: A descriptor with both key-select bits 10 and 11 set is an error: `chanStat` becomes 0x0005_0004 (code 5, setup flag 0x04). No credit is used.
- R12: A descriptor with bit 2 set and a zero link completes normally. It then halts with `chanStat` 0x0001_0000 and pulses `irq` once, even when bit 0 is clear.
- R13: After any error the engine ignores credits until `statClr` zeroes `chanStat`. It also stays disarmed until a new pointer is written.
- R14: A pointer write while busy is ignored and does not change `curPtr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptrWr | input | 1 | Load start pointer (idle only) |
| ptrData | input | AW | Start pointer byte address |
| semaWr | input | 1 | Add credits |
| semaData | input | SW | Credits to add |
| statClr | input | 1 | Clear error status and halt |
| memEn | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | AW | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, one cycle after request |
| irq | output | 1 | Completion / error pulse |
| chanStat | output | 32 | Error code (23:16) and flags (7:0) |
| semaCount | output | SW | Current credit count |
| busy | output | 1 | Engine not idle |
| curPtr | output | AW | Current descriptor address |

## Verification
A wrong credit count or wrong chaining state inside the engine shows at the ports as descriptors that run when they should not. The bench observes this as extra memory accesses, or as status words and link positions (`curPtr`) that differ from the credits granted. This shows within one descriptor time of the credit write. A wrong word counter shows as damaged marker words just past the destination block, or as a wrong access total, by the end of that descriptor. Errors are checked through the exact `chanStat` value, the missing status write-back and the single interrupt pulse.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int IDX_W = 16;

  typedef enum logic [1:0] {A_DESC, A_SRC, A_DST} addr_sel_e;

  typedef enum logic [2:0] {
    S_IDLE, S_NEXT, S_FETCH, S_CHECK, S_MRD, S_MWR, S_WB
  } state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic             memEn;
    logic             memWe;
    addr_sel_e        addrSel;
    logic [IDX_W-1:0] idx;
    logic             capDesc;
    logic [2:0]       capIdx;
    logic             loadPtr;
    logic             advPtr;
  } strobe_t;

  // descriptor word positions
  localparam logic [2:0] W_LINK = 3'd0;
  localparam logic [2:0] W_CTRL = 3'd1;
  localparam logic [2:0] W_SRC  = 3'd3;
  localparam logic [2:0] W_DST  = 3'd4;
  localparam logic [2:0] W_SIZE = 3'd5;
  localparam logic [2:0] W_STAT = 3'd7;

  // error codes and flags
  localparam logic [7:0] E_LINK0   = 8'd1;
  localparam logic [7:0] E_PAYLOAD = 8'd4;
  localparam logic [7:0] E_MODE    = 8'd5;
  localparam logic [7:0] F_PACKET  = 8'h08;
  localparam logic [7:0] F_SETUP   = 8'h04;
endpackage

// File: rtl/dce_dpath.sv
module dce_dpath import dce_pkg::*; #(
  parameter int          AW      = 16,
  parameter logic [31:0] XOR_KEY = 32'h5A5A_C3C3
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [AW-1:0] ptrIn,
  input  logic [31:0]   memRdata,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  output logic [AW-1:0] curPtr,
  output logic          descIrq,
  output logic          descDec,
  output logic          descChain,
  output logic          descModeBad,
  output logic          linkZero,
  output logic [31:0]   sizeBytes
);
  localparam int OW = IDX_W + 2;

  logic [AW-1:0] linkAddr, srcAddr, dstAddr;
  logic          fXform, fKeyOtp, fKeyPay;
  logic [OW-1:0] offWide;
  logic [AW-1:0] byteOff;

  assign offWide = {st.idx, 2'b00};
  assign byteOff = AW'(offWide);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr <= '0; linkAddr <= '0; srcAddr <= '0; dstAddr <= '0;
      sizeBytes <= '0; linkZero <= 1'b0;
      descIrq <= 1'b0; descDec <= 1'b0; descChain <= 1'b0;
      fXform <= 1'b0; fKeyOtp <= 1'b0; fKeyPay <= 1'b0;
    end else begin
      if (st.loadPtr)     curPtr <= ptrIn;
      else if (st.advPtr) curPtr <= linkAddr;
      if (st.capDesc) begin
        case (st.capIdx)
          W_LINK: begin
            linkAddr <= memRdata[AW-1:0];
            linkZero <= (memRdata == 32'd0);
          end
          W_CTRL: begin
            descIrq   <= memRdata[0];
            descDec   <= memRdata[1];
            descChain <= memRdata[2];
            fXform    <= memRdata[5];
            fKeyOtp   <= memRdata[10];
            fKeyPay   <= memRdata[11];
          end
          W_SRC:   srcAddr   <= memRdata[AW-1:0];
          W_DST:   dstAddr   <= memRdata[AW-1:0];
          W_SIZE:  sizeBytes <= memRdata;
          default: ;
        endcase
      end
    end
  end

  assign descModeBad = fKeyOtp & fKeyPay;

  always_comb begin
    case (st.addrSel)
      A_SRC:   memAddr = srcAddr + byteOff;
      A_DST:   memAddr = dstAddr + byteOff;
      default: memAddr = curPtr + byteOff;
    endcase
    if (st.addrSel == A_DESC) memWdata = 32'd1;
    else if (fXform)          memWdata = memRdata ^ XOR_KEY;
    else                      memWdata = memRdata;
  end

  // R5: descriptor fields stay frozen while data is moving
  p_src_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.memEn && st.addrSel == A_SRC) |=> $stable(srcAddr) && $stable(dstAddr));
endmodule

// File: rtl/dce_ctrl.sv
module dce_ctrl import dce_pkg::*; #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ptrWr,
  input  logic          semaWr,
  input  logic [SW-1:0] semaIn,
  input  logic          statClr,
  input  logic          descIrq,
  input  logic          descDec,
  input  logic          descChain,
  input  logic          descModeBad,
  input  logic          linkZero,
  input  logic [31:0]   sizeBytes,
  output strobe_t       st,
  output logic          irq,
  output logic [31:0]   chanStat,
  output logic [SW-1:0] semaCount,
  output logic          busy
);
  localparam logic [IDX_W-1:0] DESC_WORDS = IDX_W'(8);

  state_e           state, nState;
  logic [IDX_W-1:0] cnt, nWords;
  logic             armed, pending, halted, go, sizeBad, lastWord;
  logic             errHit, doneDec;
  logic [31:0]      errWord;
  logic [SW:0]      semaSum;

  assign go       = armed && !halted && (semaCount != '0);
  assign sizeBad  = (sizeBytes[3:0] != 4'd0) || (|sizeBytes[31:IDX_W+2]);
  assign nWords   = sizeBytes[IDX_W+1:2];
  assign lastWord = (cnt == nWords - IDX_W'(1));
  assign busy     = (state != S_IDLE);
  assign doneDec  = (state == S_WB) && descDec;

  always_comb begin
    st = '0;
    st.addrSel = A_DESC;
    nState = state;
    case (state)
      S_IDLE: begin
        if (ptrWr)   st.loadPtr = 1'b1;
        else if (go) nState = pending ? S_NEXT : S_FETCH;
      end
      S_NEXT: begin
        st.advPtr = 1'b1;
        nState = S_FETCH;
      end
      S_FETCH: begin
        st.memEn   = (cnt < DESC_WORDS);
        st.idx     = cnt;
        st.capDesc = (cnt != '0);
        st.capIdx  = cnt[2:0] - 3'd1;
        if (cnt == DESC_WORDS) nState = S_CHECK;
      end
      S_CHECK: begin
        if (sizeBad || descModeBad) nState = S_IDLE;
        else if (nWords == '0)      nState = S_WB;
        else                        nState = S_MRD;
      end
      S_MRD: begin
        st.memEn = 1'b1; st.addrSel = A_SRC; st.idx = cnt;
        nState = S_MWR;
      end
      S_MWR: begin
        st.memEn = 1'b1; st.memWe = 1'b1; st.addrSel = A_DST; st.idx = cnt;
        nState = lastWord ? S_WB : S_MRD;
      end
      S_WB: begin
        st.memEn = 1'b1; st.memWe = 1'b1; st.idx = IDX_W'(W_STAT);
        nState = S_IDLE;
      end
      default: nState = S_IDLE;
    endcase
  end

  always_comb begin
    errHit  = 1'b0;
    errWord = '0;
    if (state == S_CHECK && sizeBad) begin
      errHit = 1'b1; errWord = {8'h00, E_PAYLOAD, 8'h00, F_PACKET};
    end else if (state == S_CHECK && descModeBad) begin
      errHit = 1'b1; errWord = {8'h00, E_MODE, 8'h00, F_SETUP};
    end else if (state == S_WB && descChain && linkZero) begin
      errHit = 1'b1; errWord = {8'h00, E_LINK0, 16'h0000};
    end
    semaSum = {1'b0, semaCount} + (semaWr ? {1'b0, semaIn} : '0);
    if (doneDec) semaSum = semaSum - (SW+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; cnt <= '0; armed <= 1'b0; pending <= 1'b0;
      halted <= 1'b0; irq <= 1'b0; chanStat <= '0; semaCount <= '0;
    end else begin
      state <= nState;
      case (state)
        S_FETCH: cnt <= (nState == S_CHECK) ? '0 : cnt + IDX_W'(1);
        S_MWR:   cnt <= cnt + IDX_W'(1);
        S_MRD:   cnt <= cnt;
        default: cnt <= '0;
      endcase
      semaCount <= semaSum[SW] ? '1 : semaSum[SW-1:0];
      irq <= errHit || (state == S_WB && descIrq);
      if (st.loadPtr) begin
        armed <= 1'b1; pending <= 1'b0;
      end
      if (state == S_NEXT) pending <= 1'b0;
      if (state == S_WB) begin
        if (!descChain)     armed   <= 1'b0;
        else if (!linkZero) pending <= 1'b1;
      end
      if (statClr) begin
        chanStat <= '0; halted <= 1'b0;
      end
      if (errHit) begin
        chanStat <= errWord; halted <= 1'b1; armed <= 1'b0;
      end
    end
  end

  // R10: every halt comes with an interrupt pulse
  p_err_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> irq);
  // R7: without a credit write the count only holds or drops by one
  p_sema_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    !semaWr |=> (semaCount == $past(semaCount)) ||
                (semaCount == $past(semaCount) - SW'(1)));
  // R2: adding credits never makes the count smaller
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (semaWr && semaIn != '0) |=> semaCount >= $past(semaCount));
  // R13: a halted engine touches no memory
  p_halt_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !st.memEn);
  // R3: a descriptor fetch starts only with a credit available
  p_fetch_credit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FETCH && cnt == '0) |-> semaCount != '0);
  // R5: data moves stay inside the byte count
  p_move_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MRD || state == S_MWR) |-> cnt < nWords);
endmodule

// File: rtl/desc_chain_engine.sv
module desc_chain_engine import dce_pkg::*; #(
  parameter int          AW      = 16,
  parameter int          SW      = 8,
  parameter logic [31:0] XOR_KEY = 32'h5A5A_C3C3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ptrWr,
  input  logic [AW-1:0] ptrData,
  input  logic          semaWr,
  input  logic [SW-1:0] semaData,
  input  logic          statClr,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic          irq,
  output logic [31:0]   chanStat,
  output logic [SW-1:0] semaCount,
  output logic          busy,
  output logic [AW-1:0] curPtr
);
  strobe_t     st;
  logic        descIrq, descDec, descChain, descModeBad, linkZero;
  logic [31:0] sizeBytes;

  dce_ctrl #(.SW(SW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ptrWr(ptrWr), .semaWr(semaWr), .semaIn(semaData),
    .statClr(statClr), .descIrq(descIrq), .descDec(descDec),
    .descChain(descChain), .descModeBad(descModeBad), .linkZero(linkZero),
    .sizeBytes(sizeBytes), .st(st), .irq(irq), .chanStat(chanStat),
    .semaCount(semaCount), .busy(busy)
  );

  dce_dpath #(.AW(AW), .XOR_KEY(XOR_KEY)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .ptrIn(ptrData), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .curPtr(curPtr),
    .descIrq(descIrq), .descDec(descDec), .descChain(descChain),
    .descModeBad(descModeBad), .linkZero(linkZero), .sizeBytes(sizeBytes)
  );

  assign memEn = st.memEn;
  assign memWe = st.memWe;

  // R6: a write-back lands only at the status word of the current descriptor
  p_wb_slot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && st.addrSel == A_DESC) |-> memAddr == curPtr + AW'(28));
endmodule

// File: tb/sim_desc_chain_engine.sv
module sim_desc_chain_engine;
  localparam int AW = 16;
  localparam int SW = 8;
  localparam logic [31:0] KEY = 32'h5A5A_C3C3;
  localparam logic [31:0] C_IRQ = 32'h1, C_DEC = 32'h2, C_CHAIN = 32'h4;
  localparam logic [31:0] C_XF = 32'h20, C_KOTP = 32'h400, C_KPAY = 32'h800;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, ptrWr = 1'b0, semaWr = 1'b0, statClr = 1'b0;
  logic [AW-1:0] ptrData = '0;
  logic [SW-1:0] semaData = '0;
  logic memEn, memWe, irq, busy;
  logic [AW-1:0] memAddr, curPtr;
  logic [31:0] memWdata, chanStat;
  logic [31:0] memRdata = '0;
  logic [SW-1:0] semaCount;

  desc_chain_engine #(.AW(AW), .SW(SW), .XOR_KEY(KEY)) u0 (
    .clk(clk), .rstN(rstN), .ptrWr(ptrWr), .ptrData(ptrData),
    .semaWr(semaWr), .semaData(semaData), .statClr(statClr),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .irq(irq), .chanStat(chanStat),
    .semaCount(semaCount), .busy(busy), .curPtr(curPtr)
  );

  logic [31:0] mem [0:1023];
  always @(posedge clk)
    if (memEn) begin
      if (memWe) mem[memAddr[11:2]] <= memWdata;
      else       memRdata <= mem[memAddr[11:2]];
    end

  int checks = 0, fails = 0, irqCnt = 0, accCnt = 0;
  always @(posedge clk) begin
    if (irq)   irqCnt++;
    if (memEn) accCnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addSema(input logic [SW-1:0] v);
    semaWr = 1'b1; semaData = v; step(1); semaWr = 1'b0;
  endtask

  task automatic loadPtr(input logic [AW-1:0] p);
    ptrWr = 1'b1; ptrData = p; step(1); ptrWr = 1'b0;
  endtask

  task automatic clearStat();
    statClr = 1'b1; step(1); statClr = 1'b0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 6) begin
      step(1);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  function automatic logic [31:0] xf(input logic [31:0] w, input bit en);
    return en ? (w ^ KEY) : w;
  endfunction

  task automatic putDesc(input int base, input int link, input logic [31:0] c0,
                         input int src, input int dst, input int size);
    mem[base/4 + 0] = link;
    mem[base/4 + 1] = c0;
    mem[base/4 + 2] = 32'h0;
    mem[base/4 + 3] = src;
    mem[base/4 + 4] = dst;
    mem[base/4 + 5] = size;
    mem[base/4 + 6] = 32'h0;
    mem[base/4 + 7] = 32'h0;
  endtask

  task automatic prepData(input int src, input int dst, input int nw);
    for (int i = 0; i <= nw; i++) begin
      mem[src/4 + i] = $urandom;
      mem[dst/4 + i] = 32'hDEAD_0000 | i;
    end
  endtask

  task automatic checkData(input string req, input int src, input int dst,
                           input int nw, input bit en);
    for (int i = 0; i < nw; i++)
      check(mem[dst/4 + i] == xf(mem[src/4 + i], en), req, "moved word",
            mem[dst/4 + i], xf(mem[src/4 + i], en));
    check(mem[dst/4 + nw] == (32'hDEAD_0000 | nw), req, "word past end",
          mem[dst/4 + nw], 32'hDEAD_0000 | nw);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int irq0, acc0, sz, nw, cfg;
    bit xon, ion;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    step(4);
    rstN = 1'b1;
    step(2);

    // R1 reset state
    check(!busy && !irq, "R1", "busy/irq", {busy, irq}, 0);
    check(chanStat == 0, "R1", "chanStat", chanStat, 0);
    check(semaCount == 0 && curPtr == 0, "R1", "sema/ptr", {semaCount, curPtr}, 0);
    check(accCnt == 0, "R1", "accesses", accCnt, 0);

    // R3: pointer loaded, no credits -> nothing
    putDesc(32'h100, 0, C_IRQ | C_DEC | C_KPAY, 32'h400, 32'h800, 32);
    prepData(32'h400, 32'h800, 8);
    loadPtr(16'h100);
    step(20);
    check(accCnt == 0, "R3", "no access without credit", accCnt, 0);
    check(curPtr == 16'h100, "R3", "pointer loaded", curPtr, 32'h100);
    check(mem[32'h100/4 + 7] == 0, "R3", "status untouched", mem[32'h100/4 + 7], 0);

    // R4..R8 single directed descriptor
    irq0 = irqCnt;
    addSema(1);
    waitIdle();
    checkData("R5", 32'h400, 32'h800, 8, 1'b0);
    check(mem[32'h100/4 + 7] == 1, "R6", "status word", mem[32'h100/4 + 7], 1);
    check(semaCount == 0, "R7", "credit used", semaCount, 0);
    check(irqCnt - irq0 == 1, "R8", "irq pulses", irqCnt - irq0, 1);
    check(accCnt == 25, "R4", "access count 8+2N+1", accCnt, 25);

    // R5/R6/R8 random descriptors
    for (int k = 0; k < 6; k++) begin
      sz = 16 * ($urandom % 5);
      nw = sz / 4;
      xon = $urandom % 2;
      ion = $urandom % 2;
      cfg = C_DEC | C_KPAY | (xon ? C_XF : 0) | (ion ? C_IRQ : 0);
      putDesc(32'h140, 0, cfg, 32'h400, 32'h800, sz);
      prepData(32'h400, 32'h800, nw);
      irq0 = irqCnt; acc0 = accCnt;
      loadPtr(16'h140);
      addSema(1);
      waitIdle();
      checkData("R5", 32'h400, 32'h800, nw, xon);
      check(mem[32'h140/4 + 7] == 1, "R6", "random status", mem[32'h140/4 + 7], 1);
      check(irqCnt - irq0 == int'(ion), "R8", "random irq", irqCnt - irq0, int'(ion));
      check(accCnt - acc0 == 9 + 2 * nw, "R4", "random accesses", accCnt - acc0, 9 + 2 * nw);
      check(semaCount == 0 && chanStat == 0, "R7", "random sema/stat",
            {semaCount, chanStat[23:0]}, 0);
    end

    // R9 ring of three, credit-gated
    putDesc(32'h180, 32'h1A0, C_CHAIN | C_DEC, 32'h400, 32'h800, 16);
    putDesc(32'h1A0, 32'h1C0, C_CHAIN | C_DEC, 32'h400, 32'h800, 16);
    putDesc(32'h1C0, 32'h180, C_CHAIN | C_DEC | C_XF, 32'h400, 32'h800, 16);
    prepData(32'h400, 32'h800, 4);
    loadPtr(16'h180);
    addSema(2);
    waitIdle();
    check(mem[32'h1A0/4 + 7] == 1 && mem[32'h1C0/4 + 7] == 0, "R9", "two ran",
          {mem[32'h1A0/4 + 7][15:0], mem[32'h1C0/4 + 7][15:0]}, 32'h0001_0000);
    check(curPtr == 16'h1A0, "R9", "pointer held", curPtr, 32'h1A0);
    addSema(1);
    waitIdle();
    check(mem[32'h1C0/4 + 7] == 1 && curPtr == 16'h1C0, "R9", "resumed",
          {mem[32'h1C0/4 + 7][15:0], curPtr}, {16'h1, 16'h1C0});
    checkData("R5", 32'h400, 32'h800, 4, 1'b1);
    mem[32'h180/4 + 7] = 0;
    addSema(1);
    waitIdle();
    check(mem[32'h180/4 + 7] == 1 && curPtr == 16'h180, "R9", "ring wrap",
          {mem[32'h180/4 + 7][15:0], curPtr}, {16'h1, 16'h180});
    putDesc(32'h1E0, 32'h180, C_DEC, 32'h400, 32'h800, 16);
    loadPtr(16'h1E0);
    acc0 = accCnt;
    addSema(2);
    waitIdle();
    step(20);
    check(accCnt - acc0 == 17, "R9", "stop after unchained", accCnt - acc0, 17);
    check(semaCount == 1, "R9", "credit left", semaCount, 1);

    // R7 no decrement, R14 pointer write while busy
    putDesc(32'h200, 0, C_KPAY, 32'h400, 32'h800, 64);
    prepData(32'h400, 32'h800, 16);
    loadPtr(16'h200);
    step(4);
    loadPtr(16'h100);
    waitIdle();
    check(curPtr == 16'h200, "R14", "busy pointer write ignored", curPtr, 32'h200);
    check(semaCount == 1, "R7", "no decrement", semaCount, 1);
    checkData("R5", 32'h400, 32'h800, 16, 1'b0);

    // R10 bad size
    putDesc(32'h220, 0, C_DEC, 32'h400, 32'h800, 20);
    prepData(32'h400, 32'h800, 5);
    irq0 = irqCnt;
    loadPtr(16'h220);
    waitIdle();
    check(chanStat == 32'h0004_0008, "R10", "size error", chanStat, 32'h0004_0008);
    check(irqCnt - irq0 == 1, "R10", "error irq", irqCnt - irq0, 1);
    check(mem[32'h220/4 + 7] == 0, "R10", "no status write", mem[32'h220/4 + 7], 0);
    check(mem[32'h800/4] == 32'hDEAD_0000, "R10", "no data write", mem[32'h800/4], 32'hDEAD_0000);
    check(semaCount == 1, "R10", "credit kept", semaCount, 1);

    // R13 halted ignores credits; clear needs new pointer
    acc0 = accCnt;
    addSema(1);
    step(20);
    check(accCnt == acc0 && semaCount == 2, "R13", "halted idle",
          accCnt - acc0, 0);
    clearStat();
    check(chanStat == 0, "R13", "status cleared", chanStat, 0);
    step(20);
    check(accCnt == acc0, "R13", "disarmed after clear", accCnt - acc0, 0);

    // R11 invalid key selection
    putDesc(32'h240, 0, C_KOTP | C_KPAY | C_DEC, 32'h400, 32'h800, 16);
    loadPtr(16'h240);
    waitIdle();
    check(chanStat == 32'h0005_0004, "R11", "mode error", chanStat, 32'h0005_0004);
    check(semaCount == 2, "R11", "credit kept", semaCount, 2);
    clearStat();

    // R12 chain with null link
    putDesc(32'h260, 0, C_CHAIN | C_DEC, 32'h400, 32'h800, 16);
    prepData(32'h400, 32'h800, 4);
    irq0 = irqCnt;
    loadPtr(16'h260);
    waitIdle();
    checkData("R12", 32'h400, 32'h800, 4, 1'b0);
    check(mem[32'h260/4 + 7] == 1, "R12", "status written", mem[32'h260/4 + 7], 1);
    check(chanStat == 32'h0001_0000, "R12", "null link error", chanStat, 32'h0001_0000);
    check(irqCnt - irq0 == 1, "R12", "one irq", irqCnt - irq0, 1);
    check(semaCount == 1, "R12", "credit used", semaCount, 1);
    clearStat();

    // R2 credit add and saturation
    addSema(200);
    step(1);
    check(semaCount == 201, "R2", "add", semaCount, 201);
    addSema(100);
    step(1);
    check(semaCount == 255, "R2", "saturate", semaCount, 255);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule